// File: doc/BRIEF.md
# Packet Fetch and Dispatch Front End

This block is the instruction front end of a wide-issue core. It fetches packets of eight 32-bit instructions at a time and passes each packet through four fetch phases. The phases are address generation, address issue to memory, a wait cycle, and capture of the returned data. Two more phases follow: dispatch, which marks each slot as live or empty and scans the packet for branches, and decode. A packet that leaves decode is presented on registered slot outputs with one valid bit per slot. The execute stage consumes it on the following clock.

The front end never stalls. It has no hazard interlock, so it accepts one packet per clock for as long as it runs. A taken-branch strobe from execute reloads the fetch address with the packet-aligned target and discards every younger packet. While a branch is anywhere in the front end or in its execute window, the block holds off interrupt acceptance. A branch is recognised by its opcode byte.

Top module: `vliw_fetch_front`

## Requirements
- R1: While `rst` is high, every stage is emptied: `slot_valid` is 0, `imem_req` is 0 and `irq_take` is 0. The first address sent after reset is `RESET_VEC`, and it appears on `imem_addr` after the second clock edge with `rst` low.
- R2: Without a redirect, the addresses on `imem_addr` in consecutive requesting cycles increase by 32, which is one packet of eight 4-byte words.
- R3: A packet whose address is on `imem_addr` in cycle c appears on `out_pc`/`slot_instr` in cycle c+4. The first packet after reset is on the outputs after the sixth clock edge with `rst` low.
- R4: Memory contract: `imem_rdata` carries the packet for the address that was on `imem_addr` one cycle earlier. The output slots reproduce those words unchanged.
- R5: Slot s occupies `slot_instr[32*s +: 32]`. An all-zero word is an empty slot, and its `slot_valid` bit is 0. Every other word of a valid packet has its bit set to 1.
- R6: Packets leave at one per clock with no bubble, and `out_pc` advances by 32 each cycle.
- R7: If `br_taken` is high in cycle n, `slot_valid` is 0 in cycles n+1 to n+5. `imem_req` is 0 in cycle n+1. The target packet is requested in cycle n+2, reaches the outputs in cycle n+6, and is followed by target+32 in cycle n+7.
- R8: The five low bits of every requested address are 0. A redirect target has its low five bits cleared before it is used.
- R9: A packet holding a word whose low byte is 0xB5 counts as a branch. Interrupts are masked while such a packet is in the capture, dispatch or decode phase, and for `EX_SPAN` (default 5) cycles after it leaves decode.
- R10: `irq_take` is high in cycle c+1 exactly when `irq_req` was high in cycle c and interrupts were not masked in cycle c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Address on `imem_addr` is a live request |
| imem_addr | output | 32 | Packet-aligned fetch address |
| imem_rdata | input | 256 | Packet returned one cycle after the request |
| br_taken | input | 1 | Taken-branch strobe from execute |
| br_target | input | 32 | Branch target byte address |
| irq_req | input | 1 | Interrupt request |
| irq_take | output | 1 | Interrupt accepted this cycle |
| out_pc | output | 32 | Address of the packet on the slot outputs |
| slot_valid | output | 8 | Per-slot live bit |
| slot_instr | output | 256 | Eight decoded instruction words |

## Verification
The hardest situation to reach is an interrupt request that lands on the exact cycle a branch packet enters or leaves the masked window. The branch is only visible inside the block until it reaches the outputs. The bench therefore places the branch opcode in a chosen packet of its memory model, which fixes the packet's arrival cycle relative to reset. It then restarts the block once for every request cycle across the window and both of its edges, predicting acceptance from the cycle count alone.

// File: rtl/vf_pkg.sv
package vf_pkg;
  localparam int unsigned VF_AW     = 32;
  localparam int unsigned VF_IW     = 32;
  localparam int unsigned VF_SLOTS  = 8;
  localparam int unsigned VF_OPC_W  = 8;
  localparam logic [7:0]  VF_BR_OP  = 8'hB5;
  localparam int unsigned VF_EXSPAN = 5;
endpackage

// File: rtl/vf_fetch.sv
module vf_fetch
  import vf_pkg::*;
#(
  parameter int unsigned AW        = VF_AW,
  parameter int unsigned IW        = VF_IW,
  parameter int unsigned SLOTS     = VF_SLOTS,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                redirect,
  input  logic [AW-1:0]       redirect_pc,
  output logic                imem_req,
  output logic [AW-1:0]       imem_addr,
  input  logic [SLOTS*IW-1:0] imem_rdata,
  output logic                rd_v,
  output logic [AW-1:0]       rd_pc,
  output logic [SLOTS*IW-1:0] rd_pkt
);
  localparam int unsigned PKT_BYTES = SLOTS * IW / 8;
  localparam logic [AW-1:0] PKT_STEP = AW'(PKT_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(PKT_BYTES - 1);

  logic          gen_v, send_v, wait_v;
  logic [AW-1:0] gen_pc, send_pc, wait_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_v  <= 1'b0;
      send_v <= 1'b0;
      wait_v <= 1'b0;
      rd_v   <= 1'b0;
      gen_pc <= RESET_VEC & ALIGN_MASK;
    end else if (redirect) begin
      gen_v  <= 1'b1;
      gen_pc <= redirect_pc & ALIGN_MASK;
      send_v <= 1'b0;
      wait_v <= 1'b0;
      rd_v   <= 1'b0;
    end else begin
      gen_v  <= 1'b1;
      if (gen_v) gen_pc <= gen_pc + PKT_STEP;
      send_v <= gen_v;
      wait_v <= send_v;
      rd_v   <= wait_v;
    end
  end

  always_ff @(posedge clk) begin
    send_pc <= gen_pc;
    wait_pc <= send_pc;
    rd_pc   <= wait_pc;
    rd_pkt  <= imem_rdata;
  end

  assign imem_req  = send_v;
  assign imem_addr = send_pc;
endmodule

// File: rtl/vf_dispatch.sv
module vf_dispatch
  import vf_pkg::*;
#(
  parameter int unsigned AW    = VF_AW,
  parameter int unsigned IW    = VF_IW,
  parameter int unsigned SLOTS = VF_SLOTS,
  parameter int unsigned OPC_W = VF_OPC_W,
  parameter logic [OPC_W-1:0] BR_OP = VF_BR_OP
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                in_v,
  input  logic [AW-1:0]       in_pc,
  input  logic [SLOTS*IW-1:0] in_pkt,
  output logic                in_br,
  output logic                dp_br,
  output logic                dc_br,
  output logic [AW-1:0]       out_pc,
  output logic [SLOTS-1:0]    out_sv,
  output logic [SLOTS*IW-1:0] out_pkt
);
  logic [SLOTS-1:0] word_live, word_br;

  for (genvar s = 0; s < SLOTS; s++) begin : g_scan
    assign word_live[s] = |in_pkt[s*IW +: IW];
    assign word_br[s]   = (in_pkt[s*IW +: OPC_W] == BR_OP);
  end

  assign in_br = in_v & (|word_br);

  logic                dp_v;
  logic [AW-1:0]       dp_pc;
  logic [SLOTS-1:0]    dp_sv;
  logic [SLOTS*IW-1:0] dp_pkt;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      dp_v   <= 1'b0;
      dp_sv  <= '0;
      dp_br  <= 1'b0;
      out_sv <= '0;
      dc_br  <= 1'b0;
    end else begin
      dp_v   <= in_v;
      dp_sv  <= in_v ? word_live : '0;
      dp_br  <= in_br;
      out_sv <= dp_v ? dp_sv : '0;
      dc_br  <= dp_br;
    end
  end

  always_ff @(posedge clk) begin
    dp_pc   <= in_pc;
    dp_pkt  <= in_pkt;
    out_pc  <= dp_pc;
    out_pkt <= dp_pkt;
  end
endmodule

// File: rtl/vf_irq_gate.sv
module vf_irq_gate
  import vf_pkg::*;
#(
  parameter int unsigned EX_SPAN = VF_EXSPAN
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic rd_br,
  input  logic dp_br,
  input  logic dc_br,
  output logic irq_take
);
  localparam int unsigned CW = $clog2(EX_SPAN + 1);

  logic [CW-1:0] ex_cnt;
  logic          masked;

  assign masked = rd_br | dp_br | dc_br | (ex_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_cnt   <= '0;
      irq_take <= 1'b0;
    end else begin
      if (dc_br)              ex_cnt <= CW'(EX_SPAN);
      else if (ex_cnt != '0)  ex_cnt <= ex_cnt - 1'b1;
      irq_take <= irq_req & ~masked;
    end
  end
endmodule

// File: rtl/vliw_fetch_front.sv
module vliw_fetch_front
  import vf_pkg::*;
#(
  parameter int unsigned AW      = VF_AW,
  parameter int unsigned IW      = VF_IW,
  parameter int unsigned SLOTS   = VF_SLOTS,
  parameter int unsigned OPC_W   = VF_OPC_W,
  parameter logic [OPC_W-1:0] BR_OP = VF_BR_OP,
  parameter int unsigned EX_SPAN = VF_EXSPAN,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic                clk,
  input  logic                rst,
  output logic                imem_req,
  output logic [AW-1:0]       imem_addr,
  input  logic [SLOTS*IW-1:0] imem_rdata,
  input  logic                br_taken,
  input  logic [AW-1:0]       br_target,
  input  logic                irq_req,
  output logic                irq_take,
  output logic [AW-1:0]       out_pc,
  output logic [SLOTS-1:0]    slot_valid,
  output logic [SLOTS*IW-1:0] slot_instr
);
  logic                rd_v;
  logic [AW-1:0]       rd_pc;
  logic [SLOTS*IW-1:0] rd_pkt;
  logic                rd_br, dp_br, dc_br;

  vf_fetch #(.AW(AW), .IW(IW), .SLOTS(SLOTS), .RESET_VEC(RESET_VEC)) u_fetch (
    .clk(clk), .rst(rst),
    .redirect(br_taken), .redirect_pc(br_target),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rd_v(rd_v), .rd_pc(rd_pc), .rd_pkt(rd_pkt)
  );

  vf_dispatch #(.AW(AW), .IW(IW), .SLOTS(SLOTS), .OPC_W(OPC_W), .BR_OP(BR_OP)) u_disp (
    .clk(clk), .rst(rst), .flush(br_taken),
    .in_v(rd_v), .in_pc(rd_pc), .in_pkt(rd_pkt),
    .in_br(rd_br), .dp_br(dp_br), .dc_br(dc_br),
    .out_pc(out_pc), .out_sv(slot_valid), .out_pkt(slot_instr)
  );

  vf_irq_gate #(.EX_SPAN(EX_SPAN)) u_irq (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .rd_br(rd_br), .dp_br(dp_br), .dc_br(dc_br),
    .irq_take(irq_take)
  );
endmodule

// File: rtl/vf_checker.sv
module vf_checker #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IW    = 32,
  parameter int unsigned SLOTS = 8,
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] BR_OP = 8'hB5
) (
  input logic                clk,
  input logic                rst,
  input logic                imem_req,
  input logic [AW-1:0]       imem_addr,
  input logic                br_taken,
  input logic                irq_req,
  input logic                irq_take,
  input logic [SLOTS-1:0]    slot_valid,
  input logic [SLOTS*IW-1:0] slot_instr
);
  localparam int unsigned OFF_W = $clog2(SLOTS * IW / 8);
  localparam logic [AW-1:0] STEP = AW'(SLOTS * IW / 8);

  logic [SLOTS-1:0] live;
  logic             out_br;
  always_comb begin
    out_br = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      live[s] = |slot_instr[s*IW +: IW];
      if (slot_valid[s] && slot_instr[s*IW +: OPC_W] == BR_OP) out_br = 1'b1;
    end
  end

  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (slot_valid == '0 && !imem_req && !irq_take));

  p_seq_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (imem_req && $past(imem_req)) |-> imem_addr == $past(imem_addr) + STEP);

  p_empty_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (slot_valid & ~live) == '0);

  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (slot_valid == '0 && !imem_req));

  p_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    imem_req |-> imem_addr[OFF_W-1:0] == '0);

  p_br_mask_r9: assert property (@(posedge clk) disable iff (rst)
    out_br |=> !irq_take);

  p_take_cause_r10: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> $past(irq_req));
endmodule

bind vliw_fetch_front vf_checker #(
  .AW(AW), .IW(IW), .SLOTS(SLOTS), .OPC_W(OPC_W), .BR_OP(BR_OP)
) u_vf_chk (
  .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
  .br_taken(br_taken), .irq_req(irq_req), .irq_take(irq_take),
  .slot_valid(slot_valid), .slot_instr(slot_instr)
);

// File: tb/vliw_fetch_front_bench.sv
`timescale 1ns/1ps
module vliw_fetch_front_bench;
  localparam logic [31:0] RV = 32'h0000_0100;
  localparam int EXS = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         imem_req;
  logic [31:0]  imem_addr;
  logic [255:0] imem_rdata;
  logic         br_taken = 1'b0;
  logic [31:0]  br_target = '0;
  logic         irq_req = 1'b0;
  logic         irq_take;
  logic [31:0]  out_pc;
  logic [7:0]   slot_valid;
  logic [255:0] slot_instr;

  int tests = 0;
  int fails = 0;
  logic [15:0] br_pkt = 16'hFFFF;

  always #5 clk = ~clk;

  vliw_fetch_front u_vliw_fetch_front (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .br_taken(br_taken), .br_target(br_target),
    .irq_req(irq_req), .irq_take(irq_take), .out_pc(out_pc),
    .slot_valid(slot_valid), .slot_instr(slot_instr)
  );

  function automatic logic [31:0] word_of(logic [31:0] a, int s);
    logic [15:0] p;
    logic [31:0] d;
    d = (a - RV) >> 5;
    p = d[15:0];
    if (p[1:0] == 2'd2 && s[0]) return 32'h0;
    if (p == br_pkt && s == 7) return {p, 4'(s), 4'h0, 8'hB5};
    return {p, 4'(s), 4'h1, 8'h11};
  endfunction

  function automatic logic [255:0] pkt_of(logic [31:0] a);
    logic [255:0] r;
    for (int s = 0; s < 8; s++) r[s*32 +: 32] = word_of(a, s);
    return r;
  endfunction

  function automatic logic [7:0] sv_of(logic [31:0] a);
    logic [7:0] r;
    for (int s = 0; s < 8; s++) r[s] = (word_of(a, s) != 32'h0);
    return r;
  endfunction

  logic [255:0] mem_q;
  always_ff @(posedge clk) mem_q <= pkt_of(imem_addr);
  assign imem_rdata = mem_q;

  task automatic chk(input logic ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; br_taken = 1'b0; irq_req = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    br_pkt = 16'd5;
    do_reset();
    chk(slot_valid == 8'h0, "R1 slot_valid", 256'(slot_valid), 256'(0));
    chk(!imem_req, "R1 imem_req", 256'(imem_req), 256'(0));
    chk(!irq_take, "R1 irq_take", 256'(irq_take), 256'(0));

    // R2 R3 R4 R5 R6 R8: free-running sweep over 16 packets
    for (int e = 1; e <= 22; e++) begin
      tick();
      if (e >= 2 && e <= 17) begin
        chk(imem_req && imem_addr == RV + 32'((e - 2) * 32), "R2/R8 addr",
            256'(imem_addr), 256'(RV + 32'((e - 2) * 32)));
        if (e == 2) chk(imem_addr == RV, "R1 first addr", 256'(imem_addr), 256'(RV));
      end
      if (e >= 6) begin
        logic [31:0] a;
        a = RV + 32'((e - 6) * 32);
        chk(out_pc == a, "R3/R6 out_pc", 256'(out_pc), 256'(a));
        chk(slot_instr == pkt_of(a), "R4 slot words", slot_instr, pkt_of(a));
        chk(slot_valid == sv_of(a), "R5 slot valid", 256'(slot_valid), 256'(sv_of(a)));
      end else begin
        chk(slot_valid == 8'h0, "R3 early empty", 256'(slot_valid), 256'(0));
      end
    end

    // R9 R10: interrupt request swept across the masked window
    for (int bp = 0; bp < 2; bp++) begin
      for (int n = 1; n <= 24; n++) begin
        logic exp_take;
        br_pkt = (bp == 0) ? 16'd3 : 16'hFFFF;
        do_reset();
        for (int i = 0; i < n; i++) tick();
        irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        exp_take = (bp == 1) || !(n >= 4 + 3 && n <= 6 + 3 + EXS);
        chk(irq_take == exp_take, bp == 0 ? "R9 irq mask window" : "R10 irq accept",
            256'(irq_take), 256'(exp_take));
        tick();
        chk(!irq_take, "R10 single pulse", 256'(irq_take), 256'(0));
      end
    end

    // R7 R8: redirects with unaligned targets
    br_pkt = 16'hFFFF;
    for (int t = 0; t < 3; t++) begin
      logic [31:0] tgt, ta;
      tgt = 32'h0000_2000 + 32'(t * 32'h344) + 32'(t * 7 + 3);
      ta  = tgt & ~32'h1F;
      do_reset();
      repeat (10) tick();
      br_taken = 1'b1; br_target = tgt;
      tick();
      br_taken = 1'b0;
      chk(!imem_req, "R7 req gap", 256'(imem_req), 256'(0));
      for (int c = 1; c <= 5; c++) begin
        chk(slot_valid == 8'h0, "R7 squash", 256'(slot_valid), 256'(0));
        if (c == 5) break;
        tick();
        if (c == 1) chk(imem_req && imem_addr == ta, "R7/R8 target addr", 256'(imem_addr), 256'(ta));
      end
      tick();
      chk(out_pc == ta, "R7 target out", 256'(out_pc), 256'(ta));
      chk(slot_instr == pkt_of(ta), "R7 target words", slot_instr, pkt_of(ta));
      tick();
      chk(out_pc == ta + 32'd32, "R7/R6 next packet", 256'(out_pc), 256'(ta + 32'd32));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule